// File: doc/BRIEF.md
# Accumulator ALU with Status Byte

This block is the arithmetic core of a small 8-bit controller. It keeps an accumulator and a status byte. On each clock edge where a valid opcode is presented, it combines the accumulator with an operand byte. It can add with or without the carry, subtract with borrow, perform bitwise logic, complement, and rotate the accumulator, with or without passing through the carry. The same opcode path can also write the status byte as a whole.

The status byte holds the following fields. Parity is never stored: it is always taken from the accumulator's current value.

| Bit | Field |
|-----|-------|
| 7 | carry |
| 6 | nibble carry |
| 5 | spare flag |
| 4:3 | bank select, high bit first |
| 2 | overflow |
| 1 | user flag |
| 0 | parity |

The two bank bits relocate the eight working registers into one of four 8-byte windows at the bottom of internal RAM. A combinational address output turns a 3-bit register index into the full RAM address for the current bank.

Top module: `acc_alu`

## Requirements
- R1: While reset (`rstN` low) is asserted, and after its release until the first operation, `accOut` reads 00h and `pswOut` reads 00h.
- R2: Opcode 2h (add) loads `accOut` with accumulator plus operand, modulo 256. Opcode 3h (add with carry) also adds the carry, bit 7 of the status byte. Both set carry on a carry out of bit 7 and clear it otherwise.
- R3: For opcodes 2h and 3h, nibble carry (status bit 6) is set on a carry out of bit 3. For opcode 4h it is set on a borrow into bit 3. In every case it is cleared otherwise.
- R4: For opcodes 2h and 3h, overflow (status bit 2) is set when exactly one of the carries out of bit 6 and out of bit 7 occurs. For opcode 4h it is set when the signed result falls outside -128..127. In every case it is cleared otherwise.
- R5: Opcode 4h loads the accumulator with accumulator minus operand minus carry, modulo 256. It sets carry when that needs a borrow and clears it otherwise.
- R6: Each of the following opcodes leaves carry, nibble carry and overflow unchanged:

  | Opcode | Operation |
  |--------|-----------|
  | 1h | load the operand |
  | 5h | AND |
  | 6h | OR |
  | 7h | XOR |
  | 8h | complement |

- R7: Opcodes 9h and Ah rotate the accumulator one place left and one place right, with flags unchanged. Opcodes Bh and Ch rotate left and right through the carry: the bit shifted out lands in carry, and the old carry enters at the other end.
- R8: Status bit 0 equals 1 exactly when `accOut` holds an odd number of 1 bits, in every cycle.
- R9: `regAddr` equals {3'b000, status[4:3], `regIdx`}. Bank 0, 1, 2 and 3 therefore cover addresses 00h-07h, 08h-0Fh, 10h-17h and 18h-1Fh. The output follows `regIdx` and the bank bits within the same cycle.
- R10: Opcode Dh writes operand bits 7..1 into status bits 7..1 and leaves the accumulator unchanged. Status bit 0 cannot be written and stays equal to the accumulator parity.
- R11: With `opValid` low, or with opcode 0h, Eh or Fh, the accumulator and the status byte keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Marks `opCode` and `operand` as an operation for this edge |
| opCode | input | 4 | Operation select (encodings in R2-R7, R10, R11) |
| operand | input | 8 | Second operand or status write value |
| regIdx | input | 3 | Working register index 0..7 |
| accOut | output | 8 | Accumulator |
| pswOut | output | 8 | Status byte, parity in bit 0 |
| regAddr | output | 8 | Internal RAM address of the indexed working register |

## Verification
The accumulator and the stored status bits change on the first rising edge at which the operation is presented. Parity and the register address are combinational, so they settle in the same cycle as the accumulator and the bank bits that feed them. The bench drives each operation on a falling edge, holds it across exactly one rising edge, and compares both registers at the next falling edge against a model built from the requirements. The address output is compared on the falling edge after `regIdx` changes, with no clock edge in between.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_LDA  = 4'h1,
    OP_ADD  = 4'h2,
    OP_ADDC = 4'h3,
    OP_SUBB = 4'h4,
    OP_AND  = 4'h5,
    OP_OR   = 4'h6,
    OP_XOR  = 4'h7,
    OP_CPL  = 4'h8,
    OP_RL   = 4'h9,
    OP_RR   = 4'hA,
    OP_RLC  = 4'hB,
    OP_RRC  = 4'hC,
    OP_WPSW = 4'hD
  } aluOp_t;

  // status byte bit positions
  localparam int CY_BIT  = 7;
  localparam int AC_BIT  = 6;
  localparam int F0_BIT  = 5;
  localparam int RS1_BIT = 4;
  localparam int RS0_BIT = 3;
  localparam int OV_BIT  = 2;
  localparam int UF_BIT  = 1;
  localparam int P_BIT   = 0;

  typedef struct packed {
    logic accWe;    // load accumulator with result
    logic cyWe;     // load carry
    logic arithWe;  // load nibble carry and overflow
    logic pswWe;    // byte write of status
  } aluStrobes_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic        opValid,
  input  logic [3:0]  opCode,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    if (opValid) begin
      case (opCode)
        OP_LDA, OP_AND, OP_OR, OP_XOR, OP_CPL, OP_RL, OP_RR: begin
          strobes.accWe = 1'b1;
        end
        OP_ADD, OP_ADDC, OP_SUBB: begin
          strobes.accWe   = 1'b1;
          strobes.cyWe    = 1'b1;
          strobes.arithWe = 1'b1;
        end
        OP_RLC, OP_RRC: begin
          strobes.accWe = 1'b1;
          strobes.cyWe  = 1'b1;
        end
        OP_WPSW: strobes.pswWe = 1'b1;
        default: strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/acc_alu_bank.sv
module acc_alu_bank #(
  parameter int IDX_W  = 3,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 8
) (
  input  logic [BANK_W-1:0] bankSel,
  input  logic [IDX_W-1:0]  regIdx,
  output logic [ADDR_W-1:0] regAddr
);

  localparam int PAD_W = ADDR_W - BANK_W - IDX_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign regAddr = {{PAD_W{1'b0}}, bankSel, regIdx};
    end else begin : g_nopad
      assign regAddr = {bankSel, regIdx};
    end
  endgenerate

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobes_t       strobes,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accOut,
  output logic [7:0]        pswOut
);

  localparam int NIB_W = 4;
  localparam int LOW_W = DATA_W - 1;

  logic [DATA_W-1:0] acc;
  logic [7:1]        pswReg;
  logic              cin;

  logic [DATA_W:0]   addFull, subFull;
  logic [NIB_W:0]    addNib, subNib;
  logic [LOW_W:0]    addLow;

  logic [DATA_W-1:0] resNext;
  logic              cyNext, acNext, ovNext;

  assign cin = (opCode == OP_ADD) ? 1'b0 : pswReg[CY_BIT];

  assign addFull = {1'b0, acc} + {1'b0, operand} + {{DATA_W{1'b0}}, cin};
  assign subFull = {1'b0, acc} - {1'b0, operand} - {{DATA_W{1'b0}}, cin};
  assign addNib  = {1'b0, acc[NIB_W-1:0]} + {1'b0, operand[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, cin};
  assign subNib  = {1'b0, acc[NIB_W-1:0]} - {1'b0, operand[NIB_W-1:0]}
                 - {{NIB_W{1'b0}}, cin};
  assign addLow  = {1'b0, acc[LOW_W-1:0]} + {1'b0, operand[LOW_W-1:0]}
                 + {{LOW_W{1'b0}}, cin};

  always_comb begin
    resNext = acc;
    cyNext  = pswReg[CY_BIT];
    acNext  = pswReg[AC_BIT];
    ovNext  = pswReg[OV_BIT];
    case (opCode)
      OP_LDA:  resNext = operand;
      OP_ADD, OP_ADDC: begin
        resNext = addFull[DATA_W-1:0];
        cyNext  = addFull[DATA_W];
        acNext  = addNib[NIB_W];
        ovNext  = addFull[DATA_W] ^ addLow[LOW_W];
      end
      OP_SUBB: begin
        resNext = subFull[DATA_W-1:0];
        cyNext  = subFull[DATA_W];
        acNext  = subNib[NIB_W];
        ovNext  = (acc[DATA_W-1] ^ operand[DATA_W-1])
                & (subFull[DATA_W-1] ^ acc[DATA_W-1]);
      end
      OP_AND:  resNext = acc & operand;
      OP_OR:   resNext = acc | operand;
      OP_XOR:  resNext = acc ^ operand;
      OP_CPL:  resNext = ~acc;
      OP_RL:   resNext = {acc[DATA_W-2:0], acc[DATA_W-1]};
      OP_RR:   resNext = {acc[0], acc[DATA_W-1:1]};
      OP_RLC: begin
        resNext = {acc[DATA_W-2:0], pswReg[CY_BIT]};
        cyNext  = acc[DATA_W-1];
      end
      OP_RRC: begin
        resNext = {pswReg[CY_BIT], acc[DATA_W-1:1]};
        cyNext  = acc[0];
      end
      default: resNext = acc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      pswReg <= '0;
    end else begin
      if (strobes.accWe) acc <= resNext;
      if (strobes.pswWe) begin
        pswReg <= operand[7:1];
      end else begin
        if (strobes.cyWe) pswReg[CY_BIT] <= cyNext;
        if (strobes.arithWe) begin
          pswReg[AC_BIT] <= acNext;
          pswReg[OV_BIT] <= ovNext;
        end
      end
    end
  end

  assign accOut = acc;
  assign pswOut = {pswReg, ^acc};

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  regIdx,
  output logic [DATA_W-1:0] accOut,
  output logic [7:0]        pswOut,
  output logic [ADDR_W-1:0] regAddr
);

  aluStrobes_t strobes;

  acc_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobes (strobes)
  );

  acc_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opCode  (opCode),
    .operand (operand),
    .accOut  (accOut),
    .pswOut  (pswOut)
  );

  acc_alu_bank #(.IDX_W(IDX_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_bank (
    .bankSel (pswOut[RS1_BIT:RS0_BIT]),
    .regIdx  (regIdx),
    .regAddr (regAddr)
  );

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [3:0] opCode,
  input logic [7:0] operand,
  input logic [2:0] regIdx,
  input logic [7:0] accOut,
  input logic [7:0] pswOut,
  input logic [7:0] regAddr
);

  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_ADD) |=> accOut == 8'($past(accOut) + $past(operand)));

  // R6
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR ||
                 opCode == OP_CPL || opCode == OP_LDA))
    |=> ($stable(pswOut[CY_BIT]) && $stable(pswOut[AC_BIT]) && $stable(pswOut[OV_BIT])));

  // R8
  parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    pswOut[P_BIT] == ($countones(accOut) % 2 == 1));

  // R9
  bank_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == {3'b000, pswOut[RS1_BIT], pswOut[RS0_BIT], regIdx});

  // R10
  psw_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_WPSW) |=> (pswOut[7:1] == $past(operand[7:1]) && $stable(accOut)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(accOut) && $stable(pswOut)));

endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opCode  (opCode),
  .operand (operand),
  .regIdx  (regIdx),
  .accOut  (accOut),
  .pswOut  (pswOut),
  .regAddr (regAddr)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [3:0] opCode;
  logic [7:0] operand;
  logic [2:0] regIdx;
  logic [7:0] accOut, pswOut, regAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  int  mAcc = 0;
  bit  mCy, mAc, mF0, mOv, mUf;
  bit [1:0] mRs;

  always #10 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .operand(operand), .regIdx(regIdx), .accOut(accOut),
    .pswOut(pswOut), .regAddr(regAddr)
  );

  function automatic bit oddOnes(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 1;
  endfunction

  function automatic logic [7:0] expPsw();
    return {mCy, mAc, mF0, mRs, mOv, mUf, oddOnes(mAcc)};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    check(req, "acc", accOut, 8'(mAcc));
    check(req, "psw", pswOut, expPsw());
  endtask

  task automatic modelStep(input int code, input int b);
    int a = mAcc;
    int c = mCy;
    int r, sa, sb, sr;
    case (code)
      1: mAcc = b;
      2, 3: begin
        if (code == 2) c = 0;
        r   = a + b + c;
        mAc = ((a % 16) + (b % 16) + c) > 15;
        mOv = (((a % 128) + (b % 128) + c) > 127) != (r > 255);
        mCy = r > 255;
        mAcc = r % 256;
      end
      4: begin
        r   = a - b - c;
        mCy = r < 0;
        mAc = (a % 16) < ((b % 16) + c);
        sa  = (a > 127) ? a - 256 : a;
        sb  = (b > 127) ? b - 256 : b;
        sr  = sa - sb - c;
        mOv = (sr < -128) || (sr > 127);
        mAcc = (r + 256) % 256;
      end
      5: mAcc = a & b;
      6: mAcc = a | b;
      7: mAcc = a ^ b;
      8: mAcc = 255 - a;
      9: mAcc = ((a * 2) % 256) + (a / 128);
      10: mAcc = (a / 2) + ((a % 2) * 128);
      11: begin mAcc = ((a * 2) % 256) + c; mCy = a > 127; end
      12: begin mAcc = (a / 2) + c * 128; mCy = a % 2; end
      13: begin
        mCy = b[7]; mAc = b[6]; mF0 = b[5]; mRs = b[4:3]; mOv = b[2]; mUf = b[1];
      end
      default: ;
    endcase
  endtask

  task automatic applyOp(input logic [3:0] code, input logic [7:0] val);
    opCode  = code;
    operand = val;
    opValid = 1'b1;
    modelStep(int'(code), int'(val));
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic testReset();
    check("R1", "acc", accOut, 8'h00);
    check("R1", "psw", pswOut, 8'h00);
  endtask

  task automatic testAdd();
    applyOp(4'h1, 8'h7F); applyOp(4'h2, 8'h01); checkState("R4"); // signed overflow, nibble carry
    applyOp(4'h1, 8'hFF); applyOp(4'h2, 8'h01); checkState("R2"); // wrap with carry
    applyOp(4'h1, 8'h80); applyOp(4'h2, 8'h80); checkState("R4"); // carry and overflow
    applyOp(4'h1, 8'h08); applyOp(4'h2, 8'h08); checkState("R3"); // carry out of bit 3 only
    applyOp(4'h1, 8'hF0); applyOp(4'h2, 8'h20); applyOp(4'h3, 8'h05); checkState("R2"); // adds carry in
  endtask

  task automatic testSub();
    applyOp(4'hD, 8'h00);
    applyOp(4'h1, 8'h00); applyOp(4'h4, 8'h01); checkState("R5"); // borrow
    applyOp(4'h1, 8'h80); applyOp(4'h4, 8'h00); checkState("R5"); // carry in subtracts
    applyOp(4'h1, 8'h80); applyOp(4'h4, 8'h01); checkState("R4"); // signed overflow
    applyOp(4'h1, 8'h35); applyOp(4'h4, 8'h17); checkState("R3"); // nibble borrow
  endtask

  task automatic testLogic();
    applyOp(4'hD, 8'hC4);
    applyOp(4'h1, 8'h5A); checkState("R6");
    applyOp(4'h5, 8'h0F); checkState("R6");
    applyOp(4'h6, 8'hC0); checkState("R6");
    applyOp(4'h7, 8'hFF); checkState("R6");
    applyOp(4'h8, 8'h00); checkState("R6");
  endtask

  task automatic testRotate();
    applyOp(4'hD, 8'h00);
    applyOp(4'h1, 8'h81); applyOp(4'h9, 8'h00); checkState("R7");
    applyOp(4'hA, 8'h00); applyOp(4'hA, 8'h00); checkState("R7");
    applyOp(4'h1, 8'h81); applyOp(4'hB, 8'h00); checkState("R7"); // carry takes bit 7
    applyOp(4'hC, 8'h00); checkState("R7");                       // carry back in at bit 7
    applyOp(4'hC, 8'h00); checkState("R7");
  endtask

  task automatic testParity();
    applyOp(4'h1, 8'h01); checkState("R8");
    applyOp(4'h1, 8'h03); checkState("R8");
    applyOp(4'h1, 8'hFE); checkState("R8");
  endtask

  task automatic testPswWrite();
    applyOp(4'h1, 8'h07);
    applyOp(4'hD, 8'hFF); checkState("R10");       // bit 0 not writable
    check("R10", "parity", {7'b0, pswOut[0]}, 8'h01);
    applyOp(4'hD, 8'h00); checkState("R10");
  endtask

  task automatic testBank();
    for (int b = 0; b < 4; b++) begin
      applyOp(4'hD, 8'(b << 3));
      for (int i = 0; i < 8; i += 7) begin
        regIdx = 3'(i);
        @(negedge clk);
        check("R9", "regAddr", regAddr, 8'(b * 8 + i));
      end
    end
  endtask

  task automatic testIdle();
    applyOp(4'h1, 8'h3C);
    opCode = 4'h2; operand = 8'hFF; opValid = 1'b0;
    @(posedge clk); @(negedge clk);
    checkState("R11");
    applyOp(4'h0, 8'h11); checkState("R11");
    applyOp(4'hE, 8'h22); checkState("R11");
    applyOp(4'hF, 8'h33); checkState("R11");
  endtask

  initial begin
    rstN = 1'b0; opValid = 1'b0; opCode = 4'h0; operand = 8'h00; regIdx = 3'd0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAdd();
    testSub();
    testLogic();
    testRotate();
    testParity();
    testPswWrite();
    testBank();
    testIdle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule